// File: doc/BRIEF.md
# Floating-Point Unit System Register Bank

This block holds the small set of system registers that sit beside a floating-point unit: a read-only identification word, a read/write status and control word, a read/write exception word whose bit 30 is the unit's global enable, and two read-only feature words. A move-to or move-from register instruction reaches the bank as a single-cycle request that carries a 4-bit select, a write flag, write data and the privilege level of the requester.

Every request is checked against three conditions: the privilege level, the unit's own enable bit, and an external coprocessor-access grant. A permitted read returns its data one cycle later with a read-valid strobe. A permitted write updates a writable register at the request edge, or is dropped quietly if the target is read-only. A refused request changes nothing. One cycle later it raises an undefined-instruction strobe.

The response path is a four-state machine. ST_IDLE means no request was seen. ST_RD_DONE means a permitted read is being returned. ST_WR_DONE means a permitted write was taken. ST_FAULT means a refused request is being reported. The machine re-enters one of these states on every clock, chosen by the request in that cycle: no request goes to ST_IDLE, a permitted read to ST_RD_DONE, a permitted write to ST_WR_DONE, and any refused request to ST_FAULT. This holds from any state.

Top module: `fsr_bank`

## Requirements
- R1: The select decodes as 4'b0000 identification, 4'b0001 status/control, 4'b1000 exception, 4'b0111 feature 0, 4'b0110 feature 1. A permitted read of each returns that register's contents.
- R2: After reset, status/control reads 0x00000000, exception reads 0x00000000, feature 0 reads 0x10110221 and feature 1 reads 0x00000001. The identification word reads 0x4102314 in bits [31:4], with bits [3:0] taken from the revision input.
- R3: A permitted write to the identification word or to either feature word is discarded without an exception. Later reads return the unchanged value.
- R4: In privileged mode with the grant high, the identification, exception and feature words are accessible whatever the enable bit holds. Status/control is accessible only when the enable bit is 1.
- R5: In user mode the identification, exception and feature words are always refused. Status/control is accessible only when the enable bit is 1.
- R6: When the coprocessor-access grant is low, every request is refused.
- R7: A refused request raises the undefined-instruction strobe for exactly one cycle, one cycle after the request. It leaves all register contents unchanged and gives no read-valid.
- R8: The enable bit is bit 30 of the exception word. A write to it governs only requests issued after that write.
- R9: A select value outside the five encodings of R1 is refused as in R7.
- R10: Responses appear in the cycle after the request. Read-valid and the exception strobe are never high together, and with no request both are low. Read data is zero whenever read-valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = move to register, 0 = move from register |
| req_sel | input | 4 | Register select field |
| req_wdata | input | 32 | Write data |
| req_priv | input | 1 | 1 = privileged requester, 0 = user |
| cp_grant | input | 1 | External coprocessor-access permission |
| rev_id | input | 4 | Revision nibble for identification bits [3:0] |
| rd_data | output | 32 | Read data, zero unless rd_valid |
| rd_valid | output | 1 | Permitted read returned this cycle |
| undef_exc | output | 1 | Undefined-instruction strobe for a refused request |

## Verification
The bench builds the bank with its default parameters: 32-bit data, the enable at bit 30, and the stated reset words. At these values the reset-state reads check R2 directly. Every combination of privilege, enable, grant, all sixteen select codes and both write directions then becomes reachable, including the eleven unused codes. A write to the exception word drives the enable through both values before each group, so the same sweep covers the ordering rule of R8. It also covers the quiet drop of read-only writes, each followed at once by a read.

// File: rtl/fsr_pkg.sv
package fsr_pkg;
    localparam int SEL_W = 4;
    localparam int NREG  = 5;

    localparam int IX_ID    = 0;
    localparam int IX_STAT  = 1;
    localparam int IX_EXC   = 2;
    localparam int IX_FEAT0 = 3;
    localparam int IX_FEAT1 = 4;

    localparam logic [SEL_W-1:0] SEL_ID    = 4'b0000;
    localparam logic [SEL_W-1:0] SEL_STAT  = 4'b0001;
    localparam logic [SEL_W-1:0] SEL_EXC   = 4'b1000;
    localparam logic [SEL_W-1:0] SEL_FEAT0 = 4'b0111;
    localparam logic [SEL_W-1:0] SEL_FEAT1 = 4'b0110;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_RD_DONE = 2'd1,
        ST_WR_DONE = 2'd2,
        ST_FAULT   = 2'd3
    } rsp_state_e;

    typedef struct packed {
        logic            hit;
        logic            read_only;
        logic            need_en;
        logic            need_priv;
        logic [NREG-1:0] onehot;
    } sel_info_t;
endpackage

// File: rtl/fsr_decode.sv
module fsr_decode
    import fsr_pkg::*;
(
    input  logic [SEL_W-1:0] sel,
    output sel_info_t        info
);
    always_comb begin
        info = '0;
        unique case (sel)
            SEL_ID: begin
                info.onehot[IX_ID] = 1'b1;
                info.read_only     = 1'b1;
                info.need_priv     = 1'b1;
            end
            SEL_STAT: begin
                info.onehot[IX_STAT] = 1'b1;
                info.need_en         = 1'b1;
            end
            SEL_EXC: begin
                info.onehot[IX_EXC] = 1'b1;
                info.need_priv      = 1'b1;
            end
            SEL_FEAT0: begin
                info.onehot[IX_FEAT0] = 1'b1;
                info.read_only        = 1'b1;
                info.need_priv        = 1'b1;
            end
            SEL_FEAT1: begin
                info.onehot[IX_FEAT1] = 1'b1;
                info.read_only        = 1'b1;
                info.need_priv        = 1'b1;
            end
            default: info = '0;
        endcase
        info.hit = |info.onehot;
    end
endmodule

// File: rtl/fsr_permit.sv
module fsr_permit
    import fsr_pkg::*;
(
    input  sel_info_t info,
    input  logic      priv,
    input  logic      en,
    input  logic      grant,
    output logic      permit
);
    always_comb begin
        permit = grant & info.hit
               & (~info.need_en   | en)
               & (~info.need_priv | priv);
    end
endmodule

// File: rtl/fsr_store.sv
module fsr_store
    import fsr_pkg::*;
#(
    parameter int          DATA_W     = 32,
    parameter int          EN_BIT     = 30,
    parameter int          REV_W      = 4,
    parameter logic [DATA_W-REV_W-1:0] ID_UPPER = 28'h4102314,
    parameter logic [DATA_W-1:0] STAT_RST  = 32'h0000_0000,
    parameter logic [DATA_W-1:0] EXC_RST   = 32'h0000_0000,
    parameter logic [DATA_W-1:0] FEAT0_VAL = 32'h1011_0221,
    parameter logic [DATA_W-1:0] FEAT1_VAL = 32'h0000_0001
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stat,
    input  logic              wr_exc,
    input  logic [DATA_W-1:0] wdata,
    input  logic [REV_W-1:0]  rev,
    input  logic [NREG-1:0]   rd_onehot,
    output logic [DATA_W-1:0] rdata,
    output logic              en
);
    logic [DATA_W-1:0] stat_q;
    logic [DATA_W-1:0] exc_q;
    logic [DATA_W-1:0] word [NREG];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_q <= STAT_RST;
            exc_q  <= EXC_RST;
        end else begin
            if (wr_stat) stat_q <= wdata;
            if (wr_exc)  exc_q  <= wdata;
        end
    end

    always_comb begin
        word[IX_ID]    = {ID_UPPER, rev};
        word[IX_STAT]  = stat_q;
        word[IX_EXC]   = exc_q;
        word[IX_FEAT0] = FEAT0_VAL;
        word[IX_FEAT1] = FEAT1_VAL;
    end

    // AND-OR read mux over the one-hot select
    logic [DATA_W-1:0] part [NREG+1];
    assign part[0] = '0;
    generate
        for (genvar g = 0; g < NREG; g++) begin : g_rdmux
            assign part[g+1] = part[g] | (word[g] & {DATA_W{rd_onehot[g]}});
        end
    endgenerate
    assign rdata = part[NREG];
    assign en    = exc_q[EN_BIT];

    // R7: storage changes only through an issued write strobe
    a_r7_stat_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_stat |=> $stable(stat_q));
    a_r7_exc_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_exc |=> $stable(exc_q));
    a_r8_one_write: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({wr_stat, wr_exc}) <= 1);
endmodule

// File: rtl/fsr_bank.sv
module fsr_bank
    import fsr_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int EN_BIT = 30,
    parameter int REV_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [SEL_W-1:0]  req_sel,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              req_priv,
    input  logic              cp_grant,
    input  logic [REV_W-1:0]  rev_id,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    output logic              undef_exc
);
    sel_info_t         info;
    logic              en;
    logic              permit;
    logic              accept;
    logic              wr_stat, wr_exc;
    logic [DATA_W-1:0] rmux;
    logic [DATA_W-1:0] rd_q;
    rsp_state_e        state_q, state_d;

    fsr_decode u_dec (.sel(req_sel), .info(info));

    fsr_permit u_perm (
        .info(info), .priv(req_priv), .en(en), .grant(cp_grant), .permit(permit)
    );

    assign accept  = req_valid & permit;
    assign wr_stat = accept & req_write & info.onehot[IX_STAT];
    assign wr_exc  = accept & req_write & info.onehot[IX_EXC];

    fsr_store #(.DATA_W(DATA_W), .EN_BIT(EN_BIT), .REV_W(REV_W)) u_store (
        .clk(clk), .rst_n(rst_n), .wr_stat(wr_stat), .wr_exc(wr_exc),
        .wdata(req_wdata), .rev(rev_id), .rd_onehot(info.onehot),
        .rdata(rmux), .en(en)
    );

    // next-state selection
    always_comb begin
        if (!req_valid)      state_d = ST_IDLE;
        else if (!permit)    state_d = ST_FAULT;
        else if (req_write)  state_d = ST_WR_DONE;
        else                 state_d = ST_RD_DONE;
    end

    // state register and captured read word
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            rd_q    <= '0;
        end else begin
            state_q <= state_d;
            rd_q    <= (state_d == ST_RD_DONE) ? rmux : '0;
        end
    end

    // outputs from state
    always_comb begin
        rd_valid  = 1'b0;
        undef_exc = 1'b0;
        rd_data   = '0;
        unique case (state_q)
            ST_IDLE:    ;
            ST_WR_DONE: ;
            ST_RD_DONE: begin
                rd_valid = 1'b1;
                rd_data  = rd_q;
            end
            ST_FAULT:   undef_exc = 1'b1;
            default:    ;
        endcase
    end

    a_r10_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_valid && undef_exc));
    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!rd_valid && !undef_exc && rd_data == '0));
    a_r6_no_grant: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !cp_grant) |=> undef_exc);
    a_r9_bad_sel: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_sel != SEL_ID && req_sel != SEL_STAT && req_sel != SEL_EXC
         && req_sel != SEL_FEAT0 && req_sel != SEL_FEAT1) |=> undef_exc);
    a_r5_user_sys: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_priv && req_sel != SEL_STAT) |=> undef_exc);
    a_r4_priv_open: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_priv && cp_grant && (req_sel == SEL_ID || req_sel == SEL_EXC
         || req_sel == SEL_FEAT0 || req_sel == SEL_FEAT1)) |=> !undef_exc);
    a_r3_ro_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && req_priv && cp_grant && (req_sel == SEL_ID
         || req_sel == SEL_FEAT0 || req_sel == SEL_FEAT1)) |=> (!undef_exc && !rd_valid));
    a_r10_read_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && !undef_exc) |=> $onehot0({rd_valid, undef_exc}));
endmodule

// File: tb/fsr_bank_tb.sv
module fsr_bank_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid, req_write, req_priv, cp_grant;
    logic [3:0]  req_sel;
    logic [31:0] req_wdata;
    logic [3:0]  rev_id;
    logic [31:0] rd_data;
    logic        rd_valid, undef_exc;

    int n_checks = 0;
    int n_errors = 0;
    int cycles   = 0;

    // reference state
    logic [31:0] m_stat, m_exc;

    always #4 clk = ~clk;

    fsr_bank dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_sel(req_sel), .req_wdata(req_wdata), .req_priv(req_priv),
        .cp_grant(cp_grant), .rev_id(rev_id), .rd_data(rd_data),
        .rd_valid(rd_valid), .undef_exc(undef_exc)
    );

    function automatic bit known_sel(input logic [3:0] s);
        return s == 4'b0000 || s == 4'b0001 || s == 4'b1000 || s == 4'b0111 || s == 4'b0110;
    endfunction

    function automatic bit allowed(input logic [3:0] s, input bit pv, input bit g);
        if (!g || !known_sel(s)) return 0;
        if (s == 4'b0001) return m_exc[30];
        return pv;
    endfunction

    function automatic logic [31:0] ref_word(input logic [3:0] s);
        case (s)
            4'b0000: return {28'h4102314, rev_id};
            4'b0001: return m_stat;
            4'b1000: return m_exc;
            4'b0111: return 32'h1011_0221;
            4'b0110: return 32'h0000_0001;
            default: return 32'h0;
        endcase
    endfunction

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // one clock: drive at negedge, compare shortly after the next posedge
    task automatic cycle(input bit v, input bit w, input logic [3:0] s,
                         input logic [31:0] d, input bit pv, input bit g, input string tag);
        bit ok;
        logic [31:0] exp_rd;
        @(negedge clk);
        req_valid = v; req_write = w; req_sel = s; req_wdata = d;
        req_priv = pv; cp_grant = g;
        ok = v && allowed(s, pv, g);
        exp_rd = (ok && !w) ? ref_word(s) : 32'h0;
        @(posedge clk);
        if (ok && w && s == 4'b0001) m_stat = d;
        if (ok && w && s == 4'b1000) m_exc  = d;
        #1;
        check({tag, " R10 rd_valid"}, {31'b0, rd_valid}, {31'b0, ok && !w});
        check({tag, " R7 undef_exc"}, {31'b0, undef_exc}, {31'b0, v && !ok});
        check({tag, " R1 rd_data"}, rd_data, exp_rd);
    endtask

    function automatic string pick_tag(input logic [3:0] s, input bit pv, input bit g);
        if (!g) return "R6";
        if (!known_sel(s)) return "R9";
        if (s == 4'b0110 || s == 4'b0111 || s == 4'b0000) return pv ? "R3" : "R5";
        return pv ? "R4" : "R5";
    endfunction

    initial begin
        rst_n = 1'b0; req_valid = 0; req_write = 0; req_sel = 0; req_wdata = 0;
        req_priv = 0; cp_grant = 0; rev_id = 4'h5;
        m_stat = 32'h0; m_exc = 32'h0;
        repeat (3) @(posedge clk);
        #1;
        check("R10 reset rd_valid", {31'b0, rd_valid}, 32'h0);
        check("R7 reset undef", {31'b0, undef_exc}, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
        cycle(0, 0, 4'h0, 0, 0, 0, "R10 idle");
        // R2 reset values
        cycle(1, 0, 4'b0000, 0, 1, 1, "R2 id");
        cycle(1, 0, 4'b0111, 0, 1, 1, "R2 feat0");
        cycle(1, 0, 4'b0110, 0, 1, 1, "R2 feat1");
        cycle(1, 0, 4'b1000, 0, 1, 1, "R2 exc");
        cycle(1, 0, 4'b0001, 0, 1, 1, "R2 stat refused en0");
        cycle(1, 1, 4'b1000, 32'h4000_0000, 1, 1, "R8 set enable");
        cycle(1, 0, 4'b0001, 0, 1, 1, "R2 stat");
        // R8: enable cleared takes effect on the very next request
        cycle(1, 1, 4'b1000, 32'h0000_0000, 1, 1, "R8 clear enable");
        cycle(1, 0, 4'b0001, 0, 1, 1, "R8 stat after clear");
        // full sweep
        for (int en = 0; en < 2; en++) begin
            for (int pv = 0; pv < 2; pv++) begin
                for (int g = 0; g < 2; g++) begin
                    cycle(1, 1, 4'b1000, {1'b0, en[0], 10'h0, pv[0], g[0], 18'h0A5}, 1, 1, "R8 prime");
                    for (int s = 0; s < 16; s++) begin
                        logic [31:0] d;
                        d = {4'(s), 4'(pv), 4'(g), 4'(en), 16'hC3A5};
                        d[30] = en[0];
                        cycle(1, 1, 4'(s), d, pv[0], g[0], pick_tag(4'(s), pv[0], g[0]));
                        cycle(1, 0, 4'(s), 0, pv[0], g[0], pick_tag(4'(s), pv[0], g[0]));
                        cycle(0, 0, 4'(s), 0, pv[0], g[0], "R10 gap");
                    end
                end
            end
        end
        // R3 read-only words still hold after all writes
        cycle(1, 0, 4'b0000, 0, 1, 1, "R3 id after writes");
        cycle(1, 0, 4'b0111, 0, 1, 1, "R3 feat0 after writes");
        cycle(1, 0, 4'b0110, 0, 1, 1, "R3 feat1 after writes");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            n_errors++;
            n_checks++;
            $display("FAIL watchdog: got %0d cycles expected under 20000", cycles);
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end
endmodule